// File: doc/BRIEF.md
# DMA Channel Cycle Sequencer

This block carries out one DMA cycle for a single channel. A 32-bit control word, together with a source end pointer and a destination end pointer, is presented with a one-clock `start` pulse. The block checks the data-size and increment combination, latches the configuration, and then issues one transfer per clock. Each transfer carries a read address, a write address, a privilege level for each direction and the transfer size. Addresses are counted backward from the end pointers, so the final transfer of the cycle always lands exactly on each end pointer.

A programmable pacing interval of 2^R transfers makes the channel stop and raise `arb_req`. It holds there until the arbiter answers with `arb_grant`, then continues from the stored remaining count. When the cycle ends, `done` pulses for one clock and `wb_word` presents the control word with its count field cleared, ready to be written back. A reserved size or increment combination is refused: `err` pulses and no transfer is issued.

The FSM has five states: IDLE, RUN, PAUSE, DONE and FAULT. Its transitions are:
- IDLE to RUN on an accepted start.
- IDLE to FAULT on a start with a reserved configuration.
- RUN to DONE after the last transfer.
- RUN to PAUSE at a pacing point that is not the last transfer.
- PAUSE to RUN on a grant.
- DONE to IDLE and FAULT to IDLE unconditionally.

Control word layout:

| Bits | Field |
|---|---|
| [9:0] | transfers minus one |
| [13:10] | pacing exponent R |
| [15:14] | data size |
| [17:16] | read increment |
| [19:18] | write increment |
| [22:20] | read protection |
| [25:23] | write protection |
| [31:26] | spare, carried through to write-back |

Top module: `dma_cycle_seq`

## Requirements
- R1: A start whose data size is 3, or whose read or write increment (other than 3) is numerically below the data size, raises `err` for exactly one clock in the next cycle. No transfer is issued and `busy` stays low.
- R2: After an accepted start, the first transfer (`xfer_valid`) appears in the next cycle. Transfers then follow one per clock while not paused, and the total is the count field plus one (1 to 1024).
- R3: Size codes are 0 = byte, 1 = halfword, 2 = word. For an increment code c below 3, each address equals its end pointer minus ((remaining transfers - 1) << c), so the final transfer is at the end pointer.
- R4: With increment code 3, every address of that direction equals its end pointer.
- R5: `rd_priv` equals bit 20 and `wr_priv` equals bit 23 of the control word. Bits 21, 22, 24 and 25 have no effect on any output, and `xfer_size` equals the size field.
- R6: With R from 0 to 9, after every 2^R transfers that are not the last one, `arb_req` rises in the next cycle and holds until `arb_grant`. Transfers resume in the cycle after the grant.
- R7: With R from 10 to 15, `arb_req` never rises during the cycle.
- R8: `done` pulses for one clock in the cycle after the last transfer, with `wb_word` equal to the start word with bits [9:0] cleared. When the last transfer is also a pacing point, the end of the cycle takes precedence over the pause.
- R9: `start` is ignored while a cycle is active, and `arb_grant` is ignored outside the pause.
- R10: During and directly after reset, every output is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| start | input | 1 | Begin a cycle with the presented configuration |
| cfg_word | input | 32 | Packed control word |
| src_end | input | AW | Source end pointer |
| dst_end | input | AW | Destination end pointer |
| xfer_valid | output | 1 | A transfer is issued this cycle |
| rd_addr | output | AW | Read address of the transfer |
| wr_addr | output | AW | Write address of the transfer |
| rd_priv | output | 1 | Privileged read when high |
| wr_priv | output | 1 | Privileged write when high |
| xfer_size | output | 2 | Transfer data size code |
| arb_req | output | 1 | Paused, requesting re-arbitration |
| arb_grant | input | 1 | Resume permission while paused |
| done | output | 1 | One-clock end-of-cycle pulse |
| wb_word | output | 32 | Control word for write-back, valid with done |
| err | output | 1 | One-clock pulse for a refused start |
| busy | output | 1 | Cycle active (running or paused) |

## Verification
The expected timing is as follows:
- A start sampled at a rising edge produces either the first transfer or the `err` pulse in the very next cycle.
- Each later transfer follows one clock after the previous one.
- `arb_req` appears one clock after the 2^R-th transfer, and transfers resume one clock after the grant is sampled.
- `done` arrives exactly one clock after the last transfer.

The bench drives inputs on falling edges and samples on falling edges, so each result is read in the cycle it is due. The monitor compares each transfer in order against the queued expectation. It also checks the cycle-to-cycle adjacency of `done` to the final transfer and of resumption to the grant.

// File: rtl/dma_seq_pkg.sv
package dma_seq_pkg;

    localparam int CW_W    = 32;
    localparam int CNT_W   = 10;
    localparam int RATE_W  = 4;
    localparam int MAX_LOG = CNT_W;

    localparam logic [1:0] INC_FIXED = 2'd3;
    localparam logic [1:0] SIZE_RSVD = 2'd3;

    typedef struct packed {
        logic [5:0]        spare;
        logic [2:0]        wr_prot;
        logic [2:0]        rd_prot;
        logic [1:0]        wr_inc;
        logic [1:0]        rd_inc;
        logic [1:0]        size;
        logic [RATE_W-1:0] rate;
        logic [CNT_W-1:0]  cnt_m1;
    } cyc_ctrl_t;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_RUN,
        ST_PAUSE,
        ST_DONE,
        ST_FAULT
    } seq_state_t;

endpackage

// File: rtl/dma_cfg_check.sv
module dma_cfg_check
    import dma_seq_pkg::*;
(
    input  logic [1:0] size,
    input  logic [1:0] rd_inc,
    input  logic [1:0] wr_inc,
    output logic       legal
);

    logic rd_ok;
    logic wr_ok;

    always_comb begin
        rd_ok = (rd_inc == INC_FIXED) || (rd_inc >= size);
        wr_ok = (wr_inc == INC_FIXED) || (wr_inc >= size);
        legal = (size != SIZE_RSVD) && rd_ok && wr_ok;
    end

endmodule

// File: rtl/dma_addr_gen.sv
module dma_addr_gen
    import dma_seq_pkg::*;
#(
    parameter int AW = 32,
    parameter int CW = CNT_W
) (
    input  logic [AW-1:0] end_ptr,
    input  logic [1:0]    inc,
    input  logic [CW-1:0] left_m1,
    output logic [AW-1:0] addr
);

    logic [AW-1:0] offset;

    always_comb begin
        offset = AW'(left_m1) << inc;
        unique case (inc)
            INC_FIXED: addr = end_ptr;
            default:   addr = end_ptr - offset;
        endcase
    end

endmodule

// File: rtl/dma_arb_pacer.sv
module dma_arb_pacer
    import dma_seq_pkg::*;
#(
    parameter int CW   = CNT_W,
    parameter int RW   = RATE_W,
    parameter int LIMW = MAX_LOG
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          clear,
    input  logic          tick,
    input  logic [RW-1:0] rate,
    output logic          hit
);

    logic [CW-1:0] cnt_q;
    logic [CW:0]   target;
    logic [CW:0]   next_cnt;
    logic          capped;

    always_comb begin
        capped   = (rate >= RW'(LIMW));
        target   = (CW+1)'(1) << rate;
        next_cnt = {1'b0, cnt_q} + (CW+1)'(1);
        hit      = tick && !capped && (next_cnt == target);
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cnt_q <= '0;
        end else if (clear || hit) begin
            cnt_q <= '0;
        end else if (tick && !capped) begin
            cnt_q <= next_cnt[CW-1:0];
        end
    end

endmodule

// File: rtl/dma_cycle_seq.sv
module dma_cycle_seq
    import dma_seq_pkg::*;
#(
    parameter int AW = 32
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            start,
    input  logic [CW_W-1:0] cfg_word,
    input  logic [AW-1:0]   src_end,
    input  logic [AW-1:0]   dst_end,
    output logic            xfer_valid,
    output logic [AW-1:0]   rd_addr,
    output logic [AW-1:0]   wr_addr,
    output logic            rd_priv,
    output logic            wr_priv,
    output logic [1:0]      xfer_size,
    output logic            arb_req,
    input  logic            arb_grant,
    output logic            done,
    output logic [CW_W-1:0] wb_word,
    output logic            err,
    output logic            busy
);

    localparam int NDIR = 2;
    localparam logic [CW_W-1:0] CNT_CLR_MASK = ~CW_W'((1 << CNT_W) - 1);

    cyc_ctrl_t     cfg_in;
    cyc_ctrl_t     ctrl_q;
    seq_state_t    state_q;
    seq_state_t    state_d;
    logic [AW-1:0] src_end_q;
    logic [AW-1:0] dst_end_q;
    logic [CNT_W-1:0] left_q;
    logic          legal;
    logic          accept;
    logic          pace_hit;
    logic          running;

    logic [AW-1:0] end_arr  [NDIR];
    logic [1:0]    inc_arr  [NDIR];
    logic [AW-1:0] addr_arr [NDIR];

    assign cfg_in = cyc_ctrl_t'(cfg_word);

    dma_cfg_check u_chk_cfg (
        .size   (cfg_in.size),
        .rd_inc (cfg_in.rd_inc),
        .wr_inc (cfg_in.wr_inc),
        .legal  (legal)
    );

    assign accept  = (state_q == ST_IDLE) && start && legal;
    assign running = (state_q == ST_RUN);

    dma_arb_pacer u_pacer (
        .clk   (clk),
        .rst_n (rst_n),
        .clear (accept),
        .tick  (running),
        .rate  (ctrl_q.rate),
        .hit   (pace_hit)
    );

    always_comb begin
        end_arr[0] = src_end_q;
        end_arr[1] = dst_end_q;
        inc_arr[0] = ctrl_q.rd_inc;
        inc_arr[1] = ctrl_q.wr_inc;
    end

    for (genvar d = 0; d < NDIR; d++) begin : g_dir
        dma_addr_gen #(.AW(AW), .CW(CNT_W)) u_ag (
            .end_ptr (end_arr[d]),
            .inc     (inc_arr[d]),
            .left_m1 (left_q),
            .addr    (addr_arr[d])
        );
    end

    // State register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= ST_IDLE;
        end else begin
            state_q <= state_d;
        end
    end

    // Next-state logic
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_IDLE: begin
                if (start) begin
                    state_d = legal ? ST_RUN : ST_FAULT;
                end
            end
            ST_RUN: begin
                if (left_q == '0) begin
                    state_d = ST_DONE;
                end else if (pace_hit) begin
                    state_d = ST_PAUSE;
                end
            end
            ST_PAUSE: begin
                if (arb_grant) begin
                    state_d = ST_RUN;
                end
            end
            ST_DONE:  state_d = ST_IDLE;
            ST_FAULT: state_d = ST_IDLE;
            default:  state_d = ST_IDLE;
        endcase
    end

    // Latched configuration and remaining count
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            ctrl_q    <= '0;
            src_end_q <= '0;
            dst_end_q <= '0;
            left_q    <= '0;
        end else if (accept) begin
            ctrl_q    <= cfg_in;
            src_end_q <= src_end;
            dst_end_q <= dst_end;
            left_q    <= cfg_in.cnt_m1;
        end else if (running && (left_q != '0)) begin
            left_q    <= left_q - CNT_W'(1);
        end
    end

    // Outputs
    always_comb begin
        xfer_valid = 1'b0;
        rd_addr    = '0;
        wr_addr    = '0;
        rd_priv    = 1'b0;
        wr_priv    = 1'b0;
        xfer_size  = 2'd0;
        arb_req    = 1'b0;
        done       = 1'b0;
        wb_word    = '0;
        err        = 1'b0;
        busy       = 1'b0;
        unique case (state_q)
            ST_IDLE: ;
            ST_RUN: begin
                xfer_valid = 1'b1;
                busy       = 1'b1;
                rd_addr    = addr_arr[0];
                wr_addr    = addr_arr[1];
                rd_priv    = ctrl_q.rd_prot[0];
                wr_priv    = ctrl_q.wr_prot[0];
                xfer_size  = ctrl_q.size;
            end
            ST_PAUSE: begin
                arb_req = 1'b1;
                busy    = 1'b1;
            end
            ST_DONE: begin
                done    = 1'b1;
                wb_word = CW_W'(ctrl_q) & CNT_CLR_MASK;
            end
            ST_FAULT: err = 1'b1;
            default: ;
        endcase
    end

endmodule

// File: rtl/dma_cycle_seq_chk.sv
module dma_cycle_seq_chk
    import dma_seq_pkg::*;
#(
    parameter int AW = 32
) (
    input logic          clk,
    input logic          rst_n,
    input logic          xfer_valid,
    input logic [AW-1:0] rd_addr,
    input logic [AW-1:0] wr_addr,
    input logic          arb_req,
    input logic          arb_grant,
    input logic          done,
    input logic          err,
    input logic          busy,
    input cyc_ctrl_t     ctrl,
    input logic [AW-1:0] src_end_q,
    input logic [AW-1:0] dst_end_q
);

    // R8
    done_single_chk: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> !done);

    // R1
    err_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
        err |-> (!xfer_valid && !busy && !done));

    // R6
    arb_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (arb_req && !arb_grant) |=> arb_req);

    // R6
    arb_resume_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (arb_req && arb_grant) |=> xfer_valid);

    // R7
    no_pace_chk: assert property (@(posedge clk) disable iff (!rst_n)
        arb_req |-> (ctrl.rate < RATE_W'(MAX_LOG)));

    // R4
    rd_fixed_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (xfer_valid && ctrl.rd_inc == INC_FIXED) |-> (rd_addr == src_end_q));

    // R4
    wr_fixed_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (xfer_valid && ctrl.wr_inc == INC_FIXED) |-> (wr_addr == dst_end_q));

    // R3
    rd_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (xfer_valid && $past(xfer_valid) && ctrl.rd_inc != INC_FIXED)
        |-> (rd_addr == $past(rd_addr) + (AW'(1) << ctrl.rd_inc)));

    // R3
    wr_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (xfer_valid && $past(xfer_valid) && ctrl.wr_inc != INC_FIXED)
        |-> (wr_addr == $past(wr_addr) + (AW'(1) << ctrl.wr_inc)));

    // R10
    reset_quiet_chk: assert property (@(posedge clk)
        !rst_n |-> (!xfer_valid && !arb_req && !done && !err && !busy));

endmodule

bind dma_cycle_seq dma_cycle_seq_chk #(.AW(AW)) u_seq_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .xfer_valid (xfer_valid),
    .rd_addr    (rd_addr),
    .wr_addr    (wr_addr),
    .arb_req    (arb_req),
    .arb_grant  (arb_grant),
    .done       (done),
    .err        (err),
    .busy       (busy),
    .ctrl       (ctrl_q),
    .src_end_q  (src_end_q),
    .dst_end_q  (dst_end_q)
);

// File: tb/dma_cycle_seq_test.sv
module dma_cycle_seq_test;

    localparam int AW = 32;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          start = 1'b0;
    logic [31:0]   cfg_word = '0;
    logic [AW-1:0] src_end = '0;
    logic [AW-1:0] dst_end = '0;
    logic          xfer_valid;
    logic [AW-1:0] rd_addr;
    logic [AW-1:0] wr_addr;
    logic          rd_priv;
    logic          wr_priv;
    logic [1:0]    xfer_size;
    logic          arb_req;
    logic          done;
    logic [31:0]   wb_word;
    logic          err;
    logic          busy;
    logic          grant_q = 1'b0;
    logic          stray_g = 1'b0;

    int n_checks = 0;
    int n_fail   = 0;

    logic [67:0] xfer_exp [$];
    logic [31:0] wb_exp   [$];
    int  interval  = 0;
    int  gdelay    = 0;
    int  wcnt      = 0;
    int  xsince    = 0;
    int  arb_count = 0;
    bit  done_seen = 0;
    bit  prev_xfer = 0;
    bit  prev_arb  = 0;
    bit  prev_gnt  = 0;
    bit  prev_done = 0;

    always #5 clk = ~clk;

    dma_cycle_seq #(.AW(AW)) uut (
        .clk        (clk),
        .rst_n      (rst_n),
        .start      (start),
        .cfg_word   (cfg_word),
        .src_end    (src_end),
        .dst_end    (dst_end),
        .xfer_valid (xfer_valid),
        .rd_addr    (rd_addr),
        .wr_addr    (wr_addr),
        .rd_priv    (rd_priv),
        .wr_priv    (wr_priv),
        .xfer_size  (xfer_size),
        .arb_req    (arb_req),
        .arb_grant  (grant_q | stray_g),
        .done       (done),
        .wb_word    (wb_word),
        .err        (err),
        .busy       (busy)
    );

    task automatic check(input bit ok, input string tag,
                         input logic [67:0] act, input logic [67:0] exp);
        n_checks++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s: actual %0h expected %0h", tag, act, exp);
        end
    endtask

    // Monitor and grant responder
    always @(negedge clk) begin
        if (rst_n) begin
            if (xfer_valid) begin
                logic [67:0] got;
                got = {rd_addr, wr_addr, rd_priv, wr_priv, xfer_size};
                if (xfer_exp.size() == 0) begin
                    check(0, "R2 unexpected transfer", got, '0);
                end else begin
                    logic [67:0] e;
                    e = xfer_exp.pop_front();
                    check(got == e, "R3/R4/R5 transfer contents", got, e);
                end
                xsince++;
            end
            if (arb_req && !prev_arb) begin
                arb_count++;
                check(interval > 0 && xsince == interval,
                      "R6/R7 pause point", 68'(xsince), 68'(interval));
                xsince = 0;
            end
            if (prev_arb && prev_gnt) begin
                check(xfer_valid, "R6 resume after grant", 68'(xfer_valid), 68'd1);
            end
            if (done) begin
                check(prev_xfer, "R8 done follows last transfer", 68'(prev_xfer), 68'd1);
                check(xfer_exp.size() == 0, "R2 transfer count",
                      68'(xfer_exp.size()), 68'd0);
                if (wb_exp.size() != 0) begin
                    logic [31:0] w;
                    w = wb_exp.pop_front();
                    check(wb_word == w, "R8 write-back word", 68'(wb_word), 68'(w));
                end else begin
                    check(0, "R8 unexpected done", 68'd1, 68'd0);
                end
                check(!prev_done, "R8 done single pulse", 68'(prev_done), 68'd0);
                done_seen = 1;
                xsince    = 0;
            end
            prev_xfer = xfer_valid;
            prev_arb  = arb_req;
            prev_gnt  = grant_q;
            prev_done = done;
            if (arb_req && wcnt >= gdelay && !grant_q) begin
                grant_q = 1'b1;
                wcnt    = 0;
            end else if (arb_req && !grant_q) begin
                grant_q = 1'b0;
                wcnt++;
            end else begin
                grant_q = 1'b0;
            end
        end
    end

    task automatic run_cycle(input logic [31:0] word, input logic [31:0] se,
                             input logic [31:0] de, input int gd, input bit poke);
        int n;
        int ri;
        int wi;
        int r;
        n  = int'(word[9:0]) + 1;
        r  = int'(word[13:10]);
        ri = int'(word[17:16]);
        wi = int'(word[19:18]);
        for (int k = 0; k < n; k++) begin
            logic [31:0] rm;
            logic [31:0] ra;
            logic [31:0] wa;
            rm = 32'(n - 1 - k);
            ra = (ri == 3) ? se : se - (rm << ri);
            wa = (wi == 3) ? de : de - (rm << wi);
            xfer_exp.push_back({ra, wa, word[20], word[23], word[15:14]});
        end
        wb_exp.push_back(word & ~32'h3FF);
        interval  = (r < 10) ? (1 << r) : 0;
        gdelay    = gd;
        done_seen = 0;
        arb_count = 0;
        xsince    = 0;
        @(negedge clk);
        cfg_word = word;
        src_end  = se;
        dst_end  = de;
        start    = 1'b1;
        @(negedge clk);
        start = 1'b0;
        check(xfer_valid && busy, "R2 first transfer next cycle",
              68'({xfer_valid, busy}), 68'd3);
        if (poke) begin
            // R9: a second start and a stray grant while running
            cfg_word = 32'h0003_C000;
            src_end  = 32'hDEAD_0000;
            dst_end  = 32'hBEEF_0000;
            start    = 1'b1;
            stray_g  = 1'b1;
            @(negedge clk);
            start   = 1'b0;
            stray_g = 1'b0;
            check(xfer_valid && !err, "R9 start ignored while busy",
                  68'({xfer_valid, err}), 68'd2);
        end
        while (!done_seen) @(negedge clk);
        @(negedge clk);
        check(!done && !busy, "R8 done returns low",
              68'({done, busy}), 68'd0);
        check(arb_count == ((r < 10) ? (n - 1) / (1 << r) : 0),
              "R6/R7 number of pauses", 68'(arb_count),
              68'((r < 10) ? (n - 1) / (1 << r) : 0));
    endtask

    task automatic err_case(input logic [31:0] word, input string tag);
        @(negedge clk);
        cfg_word = word;
        start    = 1'b1;
        @(negedge clk);
        start = 1'b0;
        check(err && !xfer_valid && !busy, {"R1 refused start ", tag},
              68'({err, xfer_valid, busy}), 68'd4);
        @(negedge clk);
        check(!err && !xfer_valid && !busy, {"R1 err single pulse ", tag},
              68'({err, xfer_valid, busy}), 68'd0);
    endtask

    function automatic logic [31:0] mk(input int cnt, input int rate,
                                       input int size, input int ri, input int wi,
                                       input int rp, input int wp, input int sp);
        return {6'(sp), 3'(wp), 3'(rp), 2'(wi), 2'(ri), 2'(size), 4'(rate), 10'(cnt)};
    endfunction

    initial begin
        repeat (3) @(negedge clk);
        // R10
        check(!xfer_valid && !arb_req && !done && !err && !busy,
              "R10 outputs low in reset",
              68'({xfer_valid, arb_req, done, err, busy}), 68'd0);
        rst_n = 1'b1;
        @(negedge clk);
        check(!xfer_valid && !arb_req && !done && !err && !busy,
              "R10 outputs low after reset",
              68'({xfer_valid, arb_req, done, err, busy}), 68'd0);

        // R5: priv from bit 0 only; word size, 8 transfers, capped pacing (R7)
        run_cycle(mk(7, 12, 2, 2, 2, 3'b001, 3'b110, 6'h2A),
                  32'h1000_0100, 32'h2000_0200, 0, 0);
        // R4: byte data, fixed write address, pause every 4
        run_cycle(mk(9, 2, 0, 0, 3, 3'b110, 3'b011, 0),
                  32'h0000_0040, 32'h4000_0000, 2, 0);
        // R9: halfword, pause every 8, done precedence on 16th, pokes
        run_cycle(mk(15, 3, 1, 1, 2, 3'b111, 3'b101, 1),
                  32'h3000_0FFE, 32'h5000_1000, 1, 1);
        // R8: single transfer with rate 0, done beats pause
        run_cycle(mk(0, 0, 1, 3, 1, 3'b000, 3'b001, 0),
                  32'h0000_0022, 32'h0000_0044, 0, 0);
        // R6: pause after every transfer, immediate grant
        run_cycle(mk(3, 0, 2, 3, 2, 3'b001, 3'b000, 0),
                  32'h6000_0000, 32'h7000_0010, 0, 0);
        // R2: maximum 1024 transfers, pause at 512
        run_cycle(mk(1023, 9, 2, 2, 2, 3'b001, 3'b001, 6'h3F),
                  32'h2000_0FFC, 32'h3000_1FFC, 3, 0);
        // R7: rate 10 never pauses on a long cycle
        run_cycle(mk(40, 10, 0, 1, 0, 0, 0, 0),
                  32'h0000_1000, 32'h0000_2000, 0, 0);

        // R1
        err_case(mk(3, 0, 3, 3, 3, 0, 0, 0), "size 3");
        err_case(mk(3, 0, 1, 0, 1, 0, 0, 0), "halfword byte inc");
        err_case(mk(3, 0, 2, 2, 1, 0, 0, 0), "word halfword inc");

        // R9: grant while idle causes nothing
        @(negedge clk);
        stray_g = 1'b1;
        @(negedge clk);
        stray_g = 1'b0;
        check(!xfer_valid && !arb_req && !busy, "R9 grant ignored when idle",
              68'({xfer_valid, arb_req, busy}), 68'd0);

        $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
        $finish;
    end

    initial begin
        repeat (40000) @(posedge clk);
        n_checks++;
        n_fail++;
        $display("FAIL watchdog: actual hung expected completion");
        $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
        $finish;
    end

endmodule